// File: doc/BRIEF.md
# Register Window Pointer Controller

This block tracks which register window a processor is using. It holds a current-window index, an interrupt level and three privilege flags: supervisor, previous-supervisor and traps-enabled. It accepts four one-cycle command strobes. Save moves to the next lower window. Restore moves to the next higher window. Return-from-trap leaves a trap handler. Status write loads every field at once. The number of windows, `NWIN`, is a parameter from 2 to 32. The index wraps at both ends of that range.

Every window move is checked against a per-window invalid bitmask that comes from outside the block. If the destination window is marked invalid, the move does not happen. Instead the block reports a trap for one cycle with a type code. The same happens for a return-from-trap issued while traps are already enabled, and for a status write that names a window number that does not exist. Software reads the state as a packed 32-bit status word. The register file, the mask storage and trap dispatch live elsewhere.

Top module: `rwin_ctrl`

## Requirements
- R1: A synchronous reset leaves window index 0, supervisor 1, previous-supervisor 0, traps-enabled 0, interrupt level 0 and no trap. The status word then reads 0x00000080.
- R2: A save with a valid destination sets the index to index-1, and index 0 becomes NWIN-1.
- R3: A restore with a valid destination sets the index to index+1, and NWIN-1 becomes 0.
- R4: A save whose destination window has its mask bit set raises trap code 0x05 and changes no state.
- R5: A restore whose destination window has its mask bit set raises trap code 0x06 and changes no state.
- R6: A return-from-trap while traps-enabled is 1 raises trap code 0x02 and changes no state.
- R7: A return-from-trap while traps-enabled is 0 does the following. If the window index+1 (with wrap) is valid, it moves there, sets traps-enabled to 1 and copies previous-supervisor into supervisor. If that window is marked invalid, it raises trap code 0x06 and changes no state.
- R8: A status write whose window field (bits 4:0) is NWIN or more raises trap code 0x02 and changes no state.
- R9: A valid status write loads the window index from bits 4:0, traps-enabled from bit 5, previous-supervisor from bit 6, supervisor from bit 7 and interrupt level from bits 11:8.
- R10: The status word holds the window index in bits 4:0, traps-enabled in bit 5, previous-supervisor in bit 6, supervisor in bit 7 and interrupt level in bits 11:8. All other bits read 0.
- R11: The trap flag and code appear in the cycle after the command's clock edge and last exactly one cycle. The code reads 0x00 whenever the flag is low.
- R12: In a cycle with no command strobe, all state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_i | input | 1 | Save command strobe |
| restore_i | input | 1 | Restore command strobe |
| rett_i | input | 1 | Return-from-trap command strobe |
| wrsr_i | input | 1 | Status write command strobe |
| wrsr_data_i | input | 12 | Field bits for a status write, laid out as in the status word |
| win_invalid_i | input | NWIN | Per-window invalid mask; bit k marks window k |
| status_o | output | 32 | Packed status word |
| cwp_o | output | 5 | Current window index |
| trap_o | output | 1 | One-cycle trap flag |
| trap_code_o | output | 8 | Trap type code while trap_o is high, else 0 |

## Verification
The assertions expect at most one command strobe per cycle. The block does resolve simultaneous strobes by a fixed priority (status write, then return-from-trap, then restore, then save), but the checks are written for the single-command case. They also expect the invalid mask to be steady during the cycle a command is sampled. The directed bench raises exactly one strobe for one cycle and changes the mask only while no strobe is high. This keeps every checked scenario inside those assumptions.

// File: rtl/rwin_pkg.sv
`timescale 1ns / 1ps
package rwin_pkg;

    localparam int CWP_W   = 5;
    localparam int PIL_W   = 4;
    localparam int SW_W    = 32;
    localparam int WD_W    = 12;
    localparam int CWP_LSB = 0;
    localparam int ET_BIT  = 5;
    localparam int PS_BIT  = 6;
    localparam int S_BIT   = 7;
    localparam int PIL_LSB = 8;

    typedef logic [7:0] trap_code_t;
    localparam trap_code_t TC_NONE      = 8'h00;
    localparam trap_code_t TC_ILLEGAL   = 8'h02;
    localparam trap_code_t TC_OVERFLOW  = 8'h05;
    localparam trap_code_t TC_UNDERFLOW = 8'h06;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SAVE,
        OP_RESTORE,
        OP_RETT,
        OP_WRSR
    } op_e;

    typedef struct packed {
        logic             s;
        logic             ps;
        logic             et;
        logic [PIL_W-1:0] pil;
    } flags_t;

    typedef struct packed {
        logic [CWP_W-1:0] cwp;
        flags_t           fl;
    } arch_t;

    typedef struct packed {
        logic       fire;
        trap_code_t code;
    } trap_t;

    function automatic logic [SW_W-1:0] pack_status(arch_t a);
        logic [SW_W-1:0] w;
        w = '0;
        w[CWP_LSB +: CWP_W] = a.cwp;
        w[ET_BIT]           = a.fl.et;
        w[PS_BIT]           = a.fl.ps;
        w[S_BIT]            = a.fl.s;
        w[PIL_LSB +: PIL_W] = a.fl.pil;
        return w;
    endfunction

    function automatic arch_t unpack_status(logic [WD_W-1:0] w);
        arch_t a;
        a.cwp    = w[CWP_LSB +: CWP_W];
        a.fl.et  = w[ET_BIT];
        a.fl.ps  = w[PS_BIT];
        a.fl.s   = w[S_BIT];
        a.fl.pil = w[PIL_LSB +: PIL_W];
        return a;
    endfunction

endpackage

// File: rtl/rwin_cmd_decode.sv
`timescale 1ns / 1ps
module rwin_cmd_decode
    import rwin_pkg::*;
(
    input  logic save_i,
    input  logic restore_i,
    input  logic rett_i,
    input  logic wrsr_i,
    output op_e  op_o
);
    // Fixed priority when strobes coincide: status write highest.
    always_comb begin
        op_o = OP_NONE;
        if (wrsr_i)         op_o = OP_WRSR;
        else if (rett_i)    op_o = OP_RETT;
        else if (restore_i) op_o = OP_RESTORE;
        else if (save_i)    op_o = OP_SAVE;
    end
endmodule

// File: rtl/rwin_step.sv
`timescale 1ns / 1ps
module rwin_step
    import rwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic [CWP_W-1:0] cwp_i,
    output logic [CWP_W-1:0] up_o,
    output logic [CWP_W-1:0] dn_o
);
    localparam logic [CWP_W-1:0] LAST = CWP_W'(NWIN - 1);

    generate
        if (NWIN == (1 << CWP_W)) begin : g_natural
            // Full index range: modular arithmetic wraps by itself.
            assign up_o = cwp_i + 1'b1;
            assign dn_o = cwp_i - 1'b1;
        end else begin : g_compare
            assign up_o = (cwp_i == LAST) ? '0 : cwp_i + 1'b1;
            assign dn_o = (cwp_i == '0) ? LAST : cwp_i - 1'b1;
        end
    endgenerate
endmodule

// File: rtl/rwin_guard.sv
`timescale 1ns / 1ps
module rwin_guard
    import rwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  op_e              op_i,
    input  arch_t            cur_i,
    input  logic [CWP_W-1:0] up_i,
    input  logic [CWP_W-1:0] dn_i,
    input  logic [NWIN-1:0]  mask_i,
    input  logic [WD_W-1:0]  wdata_i,
    output arch_t            nxt_o,
    output trap_t            trap_o
);
    localparam int MASK_FULL = 1 << CWP_W;

    logic [MASK_FULL-1:0] mask_w;
    logic [CWP_W-1:0]     wr_cwp;
    logic                 wr_cwp_bad;

    assign mask_w     = MASK_FULL'(mask_i);
    assign wr_cwp     = wdata_i[CWP_LSB +: CWP_W];
    assign wr_cwp_bad = 32'(wr_cwp) >= 32'(NWIN);

    always_comb begin
        nxt_o  = cur_i;
        trap_o = '{fire: 1'b0, code: TC_NONE};
        unique case (op_i)
            OP_SAVE: begin
                if (mask_w[dn_i]) trap_o = '{fire: 1'b1, code: TC_OVERFLOW};
                else              nxt_o.cwp = dn_i;
            end
            OP_RESTORE: begin
                if (mask_w[up_i]) trap_o = '{fire: 1'b1, code: TC_UNDERFLOW};
                else              nxt_o.cwp = up_i;
            end
            OP_RETT: begin
                if (cur_i.fl.et) begin
                    trap_o = '{fire: 1'b1, code: TC_ILLEGAL};
                end else if (mask_w[up_i]) begin
                    trap_o = '{fire: 1'b1, code: TC_UNDERFLOW};
                end else begin
                    nxt_o.cwp   = up_i;
                    nxt_o.fl.et = 1'b1;
                    nxt_o.fl.s  = cur_i.fl.ps;
                end
            end
            OP_WRSR: begin
                if (wr_cwp_bad) trap_o = '{fire: 1'b1, code: TC_ILLEGAL};
                else            nxt_o  = unpack_status(wdata_i);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rwin_state.sv
`timescale 1ns / 1ps
module rwin_state
    import rwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid_i,
    input  arch_t nxt_i,
    input  trap_t trap_i,
    output arch_t arch_o,
    output trap_t trap_o
);
    localparam arch_t RESET_ARCH = '{cwp: '0,
                                     fl: '{s: 1'b1, ps: 1'b0, et: 1'b0, pil: '0}};

    arch_t arch_q;
    trap_t trap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arch_q <= RESET_ARCH;
            trap_q <= '0;
        end else begin
            if (cmd_valid_i && !trap_i.fire) arch_q <= nxt_i;
            trap_q <= cmd_valid_i ? trap_i : '0;
        end
    end

    assign arch_o = arch_q;
    assign trap_o = trap_q;

    // R4, R5, R6, R8: a reported trap comes with untouched state
    assert_trap_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        trap_q.fire |-> $stable(arch_q));

    // R11: a trap only follows a sampled command
    assert_trap_cause_R11: assert property (@(posedge clk) disable iff (rst)
        trap_q.fire |-> $past(cmd_valid_i));

    // R11: code is zero whenever no trap is flagged
    assert_trap_code_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !trap_q.fire |-> (trap_q.code == TC_NONE));

    // R12: without a command the state holds
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid_i |=> $stable(arch_q));
endmodule

// File: rtl/rwin_ctrl.sv
`timescale 1ns / 1ps
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              save_i,
    input  logic              restore_i,
    input  logic              rett_i,
    input  logic              wrsr_i,
    input  logic [WD_W-1:0]   wrsr_data_i,
    input  logic [NWIN-1:0]   win_invalid_i,
    output logic [SW_W-1:0]   status_o,
    output logic [CWP_W-1:0]  cwp_o,
    output logic              trap_o,
    output logic [7:0]        trap_code_o
);
    localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NWIN - 1);

    op_e              op;
    arch_t            arch_q;
    arch_t            arch_nxt;
    trap_t            trap_nxt;
    trap_t            trap_q;
    logic [CWP_W-1:0] cwp_up;
    logic [CWP_W-1:0] cwp_dn;

    rwin_cmd_decode u_dec (
        .save_i    (save_i),
        .restore_i (restore_i),
        .rett_i    (rett_i),
        .wrsr_i    (wrsr_i),
        .op_o      (op)
    );

    rwin_step #(.NWIN(NWIN)) u_step (
        .cwp_i (arch_q.cwp),
        .up_o  (cwp_up),
        .dn_o  (cwp_dn)
    );

    rwin_guard #(.NWIN(NWIN)) u_guard (
        .op_i    (op),
        .cur_i   (arch_q),
        .up_i    (cwp_up),
        .dn_i    (cwp_dn),
        .mask_i  (win_invalid_i),
        .wdata_i (wrsr_data_i),
        .nxt_o   (arch_nxt),
        .trap_o  (trap_nxt)
    );

    rwin_state u_state (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (op != OP_NONE),
        .nxt_i       (arch_nxt),
        .trap_i      (trap_nxt),
        .arch_o      (arch_q),
        .trap_o      (trap_q)
    );

    assign status_o    = pack_status(arch_q);
    assign cwp_o       = arch_q.cwp;
    assign trap_o      = trap_q.fire;
    assign trap_code_o = trap_q.code;

    // R8: the window index never leaves 0..NWIN-1
    assert_cwp_range_R8: assert property (@(posedge clk) disable iff (rst)
        32'(arch_q.cwp) < 32'(NWIN));

    // R2: an accepted save steps down with wrap
    assert_save_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SAVE && !trap_nxt.fire) |=>
        (arch_q.cwp == (($past(arch_q.cwp) == '0) ? LAST_WIN : $past(arch_q.cwp) - 1'b1)));

    // R3: an accepted restore steps up with wrap
    assert_restore_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RESTORE && !trap_nxt.fire) |=>
        (arch_q.cwp == (($past(arch_q.cwp) == LAST_WIN) ? '0 : $past(arch_q.cwp) + 1'b1)));

    // R6: return-from-trap with traps enabled is illegal
    assert_rett_illegal_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RETT && arch_q.fl.et) |=> (trap_o && trap_code_o == TC_ILLEGAL));

    // R7: an accepted return-from-trap enables traps and restores supervisor
    assert_rett_commit_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RETT && !trap_nxt.fire) |=>
        (arch_q.fl.et && arch_q.fl.s == $past(arch_q.fl.ps)));

    // R8: out-of-range status write is illegal
    assert_wrsr_bad_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRSR && 32'(wrsr_data_i[CWP_LSB +: CWP_W]) >= 32'(NWIN)) |=>
        (trap_o && trap_code_o == TC_ILLEGAL));

    // R10: unused status bits read zero
    assert_status_zero_R10: assert property (@(posedge clk) disable iff (rst)
        status_o[SW_W-1:PIL_LSB+PIL_W] == '0);
endmodule

// File: tb/test_rwin_ctrl.sv
`timescale 1ns / 1ps
module test_rwin_ctrl;
    localparam int NWIN = 8;
    localparam int OP_SAVE = 1, OP_RESTORE = 2, OP_RETT = 3, OP_WRSR = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            save_i = 1'b0, restore_i = 1'b0, rett_i = 1'b0, wrsr_i = 1'b0;
    logic [11:0]     wrsr_data_i = '0;
    logic [NWIN-1:0] win_invalid_i = '0;
    logic [31:0]     status_o;
    logic [4:0]      cwp_o;
    logic            trap_o;
    logic [7:0]      trap_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model of the architectural state
    int   m_cwp;
    logic m_s, m_ps, m_et;
    logic [3:0] m_pil;

    rwin_ctrl #(.NWIN(NWIN)) i_rwin_ctrl (
        .clk(clk), .rst(rst),
        .save_i(save_i), .restore_i(restore_i), .rett_i(rett_i), .wrsr_i(wrsr_i),
        .wrsr_data_i(wrsr_data_i), .win_invalid_i(win_invalid_i),
        .status_o(status_o), .cwp_o(cwp_o), .trap_o(trap_o), .trap_code_o(trap_code_o)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_word();
        return {20'h0, m_pil, m_s, m_ps, m_et, 5'(m_cwp)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
        end
    endtask

    // Drive one command for one cycle, predict, and compare after the edge.
    task automatic apply(input int op, input logic [11:0] d, input string req);
        int   tgt;
        logic etrap;
        logic [7:0] ecode;
        etrap = 1'b0;
        ecode = 8'h00;
        case (op)
            OP_SAVE: begin
                tgt = (m_cwp == 0) ? NWIN - 1 : m_cwp - 1;
                if (win_invalid_i[tgt]) begin etrap = 1'b1; ecode = 8'h05; end
                else m_cwp = tgt;
            end
            OP_RESTORE: begin
                tgt = (m_cwp == NWIN - 1) ? 0 : m_cwp + 1;
                if (win_invalid_i[tgt]) begin etrap = 1'b1; ecode = 8'h06; end
                else m_cwp = tgt;
            end
            OP_RETT: begin
                tgt = (m_cwp == NWIN - 1) ? 0 : m_cwp + 1;
                if (m_et) begin etrap = 1'b1; ecode = 8'h02; end
                else if (win_invalid_i[tgt]) begin etrap = 1'b1; ecode = 8'h06; end
                else begin m_cwp = tgt; m_et = 1'b1; m_s = m_ps; end
            end
            OP_WRSR: begin
                if (int'(d[4:0]) >= NWIN) begin etrap = 1'b1; ecode = 8'h02; end
                else begin
                    m_cwp = int'(d[4:0]); m_et = d[5]; m_ps = d[6]; m_s = d[7]; m_pil = d[11:8];
                end
            end
            default: ;
        endcase
        save_i      = (op == OP_SAVE);
        restore_i   = (op == OP_RESTORE);
        rett_i      = (op == OP_RETT);
        wrsr_i      = (op == OP_WRSR);
        wrsr_data_i = d;
        @(negedge clk);
        save_i = 1'b0; restore_i = 1'b0; rett_i = 1'b0; wrsr_i = 1'b0; wrsr_data_i = '0;
        check({req, " status"}, status_o, exp_word());
        check({req, " trap"}, 32'(trap_o), 32'(etrap));
        check({req, " code"}, 32'(trap_code_o), 32'(ecode));
    endtask

    // One idle cycle: trap gone, state held.
    task automatic idle(input string req);
        @(negedge clk);
        check({req, " idle trap"}, 32'(trap_o), 32'd0);
        check({req, " idle code"}, 32'(trap_code_o), 32'd0);
        check({req, " idle status"}, status_o, exp_word());
    endtask

    task automatic t_reset_R1();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cwp = 0; m_s = 1'b1; m_ps = 1'b0; m_et = 1'b0; m_pil = 4'h0;
        check("R1 reset status", status_o, 32'h0000_0080);
        check("R1 reset cwp", 32'(cwp_o), 32'd0);
        check("R1 reset trap", 32'(trap_o), 32'd0);
    endtask

    task automatic t_save_walk_R2();
        win_invalid_i = '0;
        apply(OP_SAVE, '0, "R2 save wrap 0->7");
        check("R2 cwp port", 32'(cwp_o), 32'(NWIN - 1));
        apply(OP_SAVE, '0, "R2 save 7->6");
    endtask

    task automatic t_restore_walk_R3();
        apply(OP_RESTORE, '0, "R3 restore 6->7");
        apply(OP_RESTORE, '0, "R3 restore wrap 7->0");
        check("R3 cwp port", 32'(cwp_o), 32'd0);
    endtask

    task automatic t_save_overflow_R4();
        win_invalid_i = 8'h80;
        apply(OP_SAVE, '0, "R4 save overflow");
        idle("R11 after overflow");
        win_invalid_i = 8'h04;
        apply(OP_SAVE, '0, "R4 save clean with other bit set");
    endtask

    task automatic t_restore_underflow_R5();
        win_invalid_i = 8'h01;
        apply(OP_RESTORE, '0, "R5 restore underflow at wrap");
        apply(OP_RESTORE, '0, "R11 back-to-back trap");
        idle("R12 hold");
        win_invalid_i = '0;
    endtask

    task automatic t_wrsr_R9();
        // cwp=3, et=0, ps=1, s=0, pil=5
        apply(OP_WRSR, 12'h543, "R9 status write");
        check("R10 field layout", status_o, 32'h0000_0543);
        // cwp=7, et=0, ps=1, s=1, pil=0xA
        apply(OP_WRSR, 12'hAC7, "R9 status write top window");
    endtask

    task automatic t_rett_R7();
        apply(OP_WRSR, 12'h043, "R9 setup cwp3 ps1 s0");
        apply(OP_RETT, '0, "R7 rett commit");
        check("R7 et set", 32'(status_o[5]), 32'd1);
        check("R7 s from ps", 32'(status_o[7]), 32'd1);
        apply(OP_WRSR, 12'h007, "R9 setup cwp7 ps0 s0");
        apply(OP_RETT, '0, "R7 rett wrap 7->0");
        apply(OP_WRSR, 12'h087, "R9 setup cwp7 s1");
        win_invalid_i = 8'h01;
        apply(OP_RETT, '0, "R7 rett underflow");
        win_invalid_i = '0;
    endtask

    task automatic t_rett_illegal_R6();
        apply(OP_WRSR, 12'h0A2, "R9 setup et1");
        apply(OP_RETT, '0, "R6 rett with traps on");
        idle("R11 after illegal");
    endtask

    task automatic t_wrsr_bad_R8();
        apply(OP_WRSR, 12'hF08, "R8 window field equal NWIN");
        apply(OP_WRSR, 12'h01F, "R8 window field 31");
        apply(OP_WRSR, 12'h0E7, "R8 window field NWIN-1 accepted");
    endtask

    initial begin
        @(negedge clk);
        t_reset_R1();
        t_save_walk_R2();
        t_restore_walk_R3();
        t_save_overflow_R4();
        t_restore_underflow_R5();
        t_wrsr_R9();
        t_rett_R7();
        t_rett_illegal_R6();
        t_wrsr_bad_R8();
        repeat (3) idle("R12 quiet");
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule